// File: doc/BRIEF.md
# Ultra DMA Read Capture with Flow Control

This block is the host-side receive path of an Ultra DMA style read. The attached device drives a 16-bit data bus and a data strobe that run on their own timing, with no relation to the host clock. The block passes the strobe and the bus through a two-stage synchronizer clocked by the system clock. It treats every change of the synchronized strobe, rising or falling, as one 16-bit transfer. It takes the bus value from a data pipeline that is delayed to match the synchronizer, so each transfer uses the bus value sampled at the same instant as the strobe change.

Each pair of transfers is joined into one 32-bit word. The words go into a four-entry buffer. A request line to the DMA engine stays high while any word is waiting. The engine takes the oldest word by pulsing an acknowledge. When three or more entries are occupied, a pause output tells the device to stop toggling. This leaves headroom for transfers that are already in the synchronizer.

If a word completes while the buffer is full and nothing is taken in the same cycle, the word is dropped and a sticky overrun flag is set. The flag stays set until a clear input is asserted. Capture is correct only while the system clock is fast enough compared with the strobe: each strobe level, with its data, must be held for at least two system clock cycles.

The pairing logic is a two-state machine:
- `PK_WAIT_LO`: waiting for the first half. A strobe edge stores the low half and moves to `PK_WAIT_HI`.
- `PK_WAIT_HI`: holding the low half. A strobe edge emits the packed word and returns to `PK_WAIT_LO`.

The overrun flag is a second two-state machine:
- `OV_CLEAR`: a dropped word moves it to `OV_FLAGGED`.
- `OV_FLAGGED`: a clear without a new drop in the same cycle returns it to `OV_CLEAR`.

Top module: `udma_rx_capture`

## Requirements
- R1: While `rst_n` is low, `dma_req`, `dev_pause` and `overrun` are 0. The buffer is empty and the pairing state is `PK_WAIT_LO`.
- R2: Each toggle of `dev_strobe` (0 to 1 or 1 to 0) captures one 16-bit transfer, provided each strobe level and its data are held for at least two clock cycles. A completed word is visible on `dma_req` no later than the third rising clock edge after the completing strobe change.
- R3: In a packed word, bits 15:0 hold the first transfer of the pair and bits 31:16 hold the second.
- R4: A single unpaired transfer never raises `dma_req`.
- R5: `dma_req` is 1 exactly while the buffer holds at least one word. `dma_data` shows the oldest word and stays stable until `dma_ack` is high at a rising edge. Each such acknowledge removes one word, and words leave in arrival order.
- R6: `dev_pause` is 1 exactly while 3 or more of the 4 buffer entries are occupied.
- R7: A word that completes while 4 entries are occupied, with no acknowledge in the same cycle, is discarded. The buffered words are unchanged and `overrun` becomes 1.
- R8: `overrun` stays 1 until `overrun_clr` is high at a rising edge, and then returns to 0.
- R9: `dma_ack` asserted while `dma_req` is 0 has no effect on the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_strobe | input | 1 | Device data strobe, asynchronous |
| dev_data | input | 16 | Device data bus, asynchronous |
| dev_pause | output | 1 | Asks the device to stop sending |
| dma_req | output | 1 | A packed word is waiting |
| dma_ack | input | 1 | Takes the oldest packed word |
| dma_data | output | 32 | Oldest packed word |
| overrun | output | 1 | Sticky flag: a word was dropped |
| overrun_clr | input | 1 | Clears the overrun flag |

## Verification
The assertions check, on every cycle, the properties that hold over time:
- a waiting word neither disappears nor changes until it is acknowledged;
- the overrun flag is sticky;
- an overrun can only start while the pause was already raised;
- a new request is always preceded by a detected strobe edge;
- outputs stay idle during reset.

Some behaviour only the bench scenarios can show:
- the order of the halves within a packed word;
- that an unpaired half-transfer raises no request;
- the exact occupancy at which the pause changes;
- that a dropped word leaves the buffered words intact;
- first-in first-out order over streams of varied data patterns.

// File: rtl/udma_rx_pkg.sv
package udma_rx_pkg;
    typedef enum logic [0:0] {
        PK_WAIT_LO = 1'b0,
        PK_WAIT_HI = 1'b1
    } pack_state_e;

    typedef enum logic [0:0] {
        OV_CLEAR   = 1'b0,
        OV_FLAGGED = 1'b1
    } ovr_state_e;
endpackage

// File: rtl/udma_strobe_sync.sv
module udma_strobe_sync #(
    parameter int HALF_W = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [HALF_W-1:0] data_i,
    output logic              edge_o,
    output logic [HALF_W-1:0] data_o
);
    // One flop beyond the synchronizer keeps the previous level for edge detection.
    logic [STAGES:0]   strobe_q;
    logic [HALF_W-1:0] data_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= '0;
        end else begin
            strobe_q <= {strobe_q[STAGES-1:0], strobe_i};
        end
    end

    // Data pipeline of the same depth as the synchronizer.
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_data_pipe
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) data_q[g] <= '0;
                    else        data_q[g] <= data_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) data_q[g] <= '0;
                    else        data_q[g] <= data_q[g-1];
                end
            end
        end
    endgenerate

    assign edge_o = strobe_q[STAGES-1] ^ strobe_q[STAGES];
    assign data_o = data_q[STAGES-1];
endmodule

// File: rtl/udma_word_packer.sv
module udma_word_packer
    import udma_rx_pkg::*;
#(
    parameter int HALF_W = 16,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              word_valid_o,
    output logic [WORD_W-1:0] word_o
);
    pack_state_e       state_q, state_d;
    logic [HALF_W-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PK_WAIT_LO;
            low_q   <= '0;
        end else begin
            state_q <= state_d;
            if (edge_i && state_q == PK_WAIT_LO) begin
                low_q <= half_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PK_WAIT_LO: if (edge_i) state_d = PK_WAIT_HI;
            PK_WAIT_HI: if (edge_i) state_d = PK_WAIT_LO;
            default:                state_d = PK_WAIT_LO;
        endcase
    end

    always_comb begin
        word_valid_o = 1'b0;
        word_o       = {half_i, low_q};
        unique case (state_q)
            PK_WAIT_LO: word_valid_o = 1'b0;
            PK_WAIT_HI: word_valid_o = edge_i;
            default:    word_valid_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/udma_word_fifo.sv
module udma_word_fifo
    import udma_rx_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int DEPTH     = 4,
    parameter int PAUSE_LVL = 3,
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [WORD_W-1:0] push_data_i,
    input  logic              pop_i,
    input  logic              ovr_clr_i,
    output logic [WORD_W-1:0] head_o,
    output logic              not_empty_o,
    output logic              near_full_o,
    output logic              overrun_o
);
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              pop_ok, wr_ok, drop;
    ovr_state_e        ovr_q, ovr_d;

    // A pop in the same cycle frees the slot that a push into a full buffer needs.
    assign pop_ok = pop_i && (cnt_q != '0);
    assign wr_ok  = push_i && ((cnt_q < CNT_W'(DEPTH)) || pop_ok);
    assign drop   = push_i && !wr_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({wr_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[s] <= '0;
                end else if (wr_ok && wr_ptr_q == PTR_W'(s)) begin
                    mem_q[s] <= push_data_i;
                end
            end
        end
    endgenerate

    // Overrun flag state machine.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovr_q <= OV_CLEAR;
        else        ovr_q <= ovr_d;
    end

    always_comb begin
        ovr_d = ovr_q;
        unique case (ovr_q)
            OV_CLEAR:   if (drop)                   ovr_d = OV_FLAGGED;
            OV_FLAGGED: if (ovr_clr_i && !drop)     ovr_d = OV_CLEAR;
            default:                                ovr_d = OV_CLEAR;
        endcase
    end

    always_comb begin
        overrun_o   = (ovr_q == OV_FLAGGED);
        head_o      = mem_q[rd_ptr_q];
        not_empty_o = (cnt_q != '0);
        near_full_o = (cnt_q >= CNT_W'(PAUSE_LVL));
    end
endmodule

// File: rtl/udma_rx_capture.sv
module udma_rx_capture
    import udma_rx_pkg::*;
#(
    parameter int HALF_W    = 16,
    parameter int SYNC_LEN  = 2,
    parameter int DEPTH     = 4,
    parameter int PAUSE_LVL = 3,
    localparam int WORD_W   = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_strobe,
    input  logic [HALF_W-1:0] dev_data,
    output logic              dev_pause,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [WORD_W-1:0] dma_data,
    output logic              overrun,
    input  logic              overrun_clr
);
    logic              strobe_edge;
    logic [HALF_W-1:0] half_word;
    logic              word_valid;
    logic [WORD_W-1:0] packed_word;

    udma_strobe_sync #(.HALF_W(HALF_W), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (dev_strobe),
        .data_i   (dev_data),
        .edge_o   (strobe_edge),
        .data_o   (half_word)
    );

    udma_word_packer #(.HALF_W(HALF_W)) u_pack (
        .clk          (clk),
        .rst_n        (rst_n),
        .edge_i       (strobe_edge),
        .half_i       (half_word),
        .word_valid_o (word_valid),
        .word_o       (packed_word)
    );

    udma_word_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .PAUSE_LVL(PAUSE_LVL)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (word_valid),
        .push_data_i (packed_word),
        .pop_i       (dma_ack),
        .ovr_clr_i   (overrun_clr),
        .head_o      (dma_data),
        .not_empty_o (dma_req),
        .near_full_o (dev_pause),
        .overrun_o   (overrun)
    );
endmodule

// File: rtl/udma_rx_capture_checker.sv
module udma_rx_capture_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              edge_det,
    input logic              dev_pause,
    input logic              dma_req,
    input logic              dma_ack,
    input logic [WORD_W-1:0] dma_data,
    input logic              overrun,
    input logic              overrun_clr
);
    // R1: outputs idle while reset is held.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |-> (!dma_req && !dev_pause && !overrun));

    // R5: a waiting word is not lost without an acknowledge.
    a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    // R5: the oldest word stays stable until it is taken.
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> $stable(dma_data));

    // R8: the overrun flag is sticky until cleared.
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !overrun_clr) |=> overrun);

    // R7: an overrun can only start while the buffer was already near full.
    a_r7_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(dev_pause));

    // R2: a new request follows a detected strobe edge.
    a_r2_req_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> $past(edge_det));
endmodule

bind udma_rx_capture udma_rx_capture_checker #(.WORD_W(WORD_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_det    (strobe_edge),
    .dev_pause   (dev_pause),
    .dma_req     (dma_req),
    .dma_ack     (dma_ack),
    .dma_data    (dma_data),
    .overrun     (overrun),
    .overrun_clr (overrun_clr)
);

// File: tb/udma_rx_capture_tb_top.sv
`timescale 1ns/1ps
module udma_rx_capture_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_strobe = 1'b0;
    logic [15:0] dev_data = '0;
    logic        dev_pause;
    logic        dma_req;
    logic        dma_ack;
    logic [31:0] dma_data;
    logic        overrun;
    logic        overrun_clr = 1'b0;
    logic        mon_ack = 1'b0;
    logic        tb_ack = 1'b0;
    logic        mon_en = 1'b0;
    logic        finished = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_q [$];

    assign dma_ack = mon_ack | tb_ack;

    always #4 clk = ~clk;

    udma_rx_capture dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev_strobe  (dev_strobe),
        .dev_data    (dev_data),
        .dev_pause   (dev_pause),
        .dma_req     (dma_req),
        .dma_ack     (dma_ack),
        .dma_data    (dma_data),
        .overrun     (overrun),
        .overrun_clr (overrun_clr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Driver: one strobe toggle carrying one 16-bit transfer.
    task automatic toggle(input logic [15:0] half);
        @(negedge clk);
        dev_data   = half;
        dev_strobe = ~dev_strobe;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_word(input logic [31:0] w, input bit accepted);
        toggle(w[15:0]);
        if (accepted) exp_q.push_back(w);
        toggle(w[31:16]);
    endtask

    // Monitor: takes and compares words while enabled.
    initial begin
        forever begin
            @(negedge clk);
            mon_ack = 1'b0;
            if (mon_en && dma_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected word", dma_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    check(dma_data === e, "R3/R5 word order/content", dma_data, e);
                end
                mon_ack = 1'b1;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'h0, 32'h0);
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        check({dma_req, dev_pause, overrun} === 3'b000, "R1 reset outputs",
              {29'h0, dma_req, dev_pause, overrun}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dma_req === 1'b0, "R1 idle after reset", {31'h0, dma_req}, 32'h0);

        // R4: one unpaired transfer raises no request.
        mon_en = 1'b1;
        toggle(16'hA5A5);
        repeat (4) @(negedge clk);
        check(dma_req === 1'b0, "R4 single transfer", {31'h0, dma_req}, 32'h0);
        exp_q.push_back(32'h5A5A_A5A5);
        toggle(16'h5A5A);
        repeat (4) @(negedge clk);

        // R2/R3: a stream of varied patterns, drained in flight.
        send_word(32'h0002_0001, 1'b1);
        send_word(32'hFFFF_0000, 1'b1);
        send_word(32'h0000_FFFF, 1'b1);
        for (int i = 0; i < 6; i++) begin
            send_word({16'(i * 16'h1111), 16'(16'hC000 ^ i)}, 1'b1);
        end
        repeat (8) @(negedge clk);
        check(exp_q.size() == 0, "R2 all words delivered", exp_q.size(), 32'h0);
        check(dma_req === 1'b0, "R5 request low when empty", {31'h0, dma_req}, 32'h0);

        // R9: an acknowledge with nothing waiting is ignored.
        mon_en = 1'b0;
        @(negedge clk);
        tb_ack = 1'b1;
        repeat (2) @(negedge clk);
        tb_ack = 1'b0;
        send_word(32'h1234_5678, 1'b1);
        check(dma_req === 1'b1, "R9 word kept after idle ack", {31'h0, dma_req}, 32'h1);
        check(dma_data === 32'h1234_5678, "R5 head word", dma_data, 32'h1234_5678);

        // R6: pause threshold.
        send_word(32'h2222_1111, 1'b1);
        check(dev_pause === 1'b0, "R6 pause low at 2", {31'h0, dev_pause}, 32'h0);
        send_word(32'h4444_3333, 1'b1);
        check(dev_pause === 1'b1, "R6 pause high at 3", {31'h0, dev_pause}, 32'h1);
        send_word(32'h6666_5555, 1'b1);
        check(overrun === 1'b0, "R7 no overrun at 4", {31'h0, overrun}, 32'h0);

        // R7: a fifth word is dropped.
        send_word(32'hDEAD_BEEF, 1'b0);
        check(overrun === 1'b1, "R7 overrun set", {31'h0, overrun}, 32'h1);
        check(dma_data === 32'h1234_5678, "R7 head unchanged", dma_data, 32'h1234_5678);
        repeat (5) @(negedge clk);
        check(overrun === 1'b1, "R8 overrun sticky", {31'h0, overrun}, 32'h1);
        overrun_clr = 1'b1;
        @(negedge clk);
        overrun_clr = 1'b0;
        check(overrun === 1'b0, "R8 overrun cleared", {31'h0, overrun}, 32'h0);

        // Drain the four kept words in order.
        mon_en = 1'b1;
        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R7 kept words drained", exp_q.size(), 32'h0);
        check(dev_pause === 1'b0, "R6 pause low when drained", {31'h0, dev_pause}, 32'h0);
        check(dma_req === 1'b0, "R5 empty after drain", {31'h0, dma_req}, 32'h0);
        finish_up();
    end
endmodule